// File: doc/BRIEF.md
# Serial ADC Power-State Frame Controller

This block is the digital control side of a serial sampling converter. The converter has an active-low chip-select, a serial clock and a three-state data pin. The host opens a frame by pulling chip-select low. It then clocks the frame with falling serial-clock edges and closes the frame by releasing chip-select. The block counts the falling edges in each frame. When chip-select rises, it uses that count to decide one of three outcomes: the frame was an ordinary conversion, it asked the converter to sleep, or it woke the converter with a dummy conversion.

Both interface inputs are brought into one system clock domain through synchroniser chains, and edges are found there. A shift register loads a sample word from a parallel input at the start of each frame. It presents the word MSB first, advancing one bit per counted falling edge. The power state, the per-frame data-valid flag and a frame-end pulse all change in the same system clock cycle, once the rising chip-select has been detected. Small count windows guard against entering or leaving sleep because of short chip-select glitches or short clock bursts.

Top module: `pdc_adc_ctl`

## Requirements
- R1: Falling serial-clock edges are counted only while a frame is open. A falling edge seen in the same cycle as the opening chip-select edge is not counted. The count saturates at FRAME_LEN (16), so falling edges beyond the 16th have no effect on the frame outcome.
- R2: In a frame that starts powered, a count of 2 to 9 when chip-select rises drives pwr_up to 0 (sleep).
- R3: In a frame that starts powered, a count of 0 or 1 when chip-select rises keeps pwr_up at 1.
- R4: In a frame that starts powered, a count of 10 or more when chip-select rises keeps pwr_up at 1.
- R5: In a frame that starts asleep, a count below 10 when chip-select rises keeps pwr_up at 0. This includes a burst of 8 edges.
- R6: In a frame that starts asleep, a count of 10 or more when chip-select rises sets pwr_up to 1.
- R7: data_valid is set to 1 at frame end only when the frame started powered and reached 16 counted edges. Otherwise it is set to 0. A wake-up frame therefore always reports 0, and the frame after it can report 1.
- R8: sdata_oe is 1 while a frame is open and 0 otherwise. It is already 0 in the cycle in which pwr_up falls.
- R9: At frame start, sample_in is loaded. sdata_out then shows bit DATA_W-1 first, and each counted falling edge advances it to the next lower bit.
- R10: frame_done is a one-cycle pulse for each frame end. pwr_up and data_valid take their new values in that cycle and hold them until the next frame end.
- R11: While rst_n is low and right after it rises: pwr_up is 1, and data_valid, sdata_oe and frame_done are 0.
- R12: A falling serial-clock edge detected in the same cycle as the closing chip-select edge is counted toward that frame's outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cs_n_in | input | 1 | Chip-select from the host, active low, asynchronous to clk |
| sclk_in | input | 1 | Serial clock from the host, idles high, asynchronous to clk |
| sample_in | input | DATA_W | Sample word loaded at each frame start |
| sdata_out | output | 1 | Serial data bit, MSB first |
| sdata_oe | output | 1 | Drive enable for the data pin; 0 means high impedance |
| pwr_up | output | 1 | 1 = powered, 0 = powered down |
| data_valid | output | 1 | Whether the last closed frame carried valid data |
| frame_done | output | 1 | One-cycle pulse at each detected frame end |

## Verification
The closing chip-select edge and the final falling serial-clock edge can land in the same synchronised cycle. In that cycle the frame verdict and the edge count are both being settled. The bench provokes this by changing both inputs at the same instant, so their equal-length synchroniser chains deliver both edges together. It does so with the 2nd edge of a powered frame, the 10th edge of a sleeping frame, and the 16th edge of a full frame. Each case is judged by the power state and data-valid flag popped from the scoreboard at frame_done. These show whether the coincident edge was counted: sleep, wake and valid data are expected, in that order.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // Synchronised view of one asynchronous input.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_ev_t;

    // Outcome of a frame, decided when chip-select rises.
    typedef enum logic [1:0] {
        VERDICT_KEEP  = 2'd0,
        VERDICT_SLEEP = 2'd1,
        VERDICT_WAKE  = 2'd2
    } verdict_e;

endpackage

// File: rtl/pdc_edge_sync.sv
module pdc_edge_sync
    import pdc_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     async_in,
    output edge_ev_t ev
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
            st_q.prev  <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ev.level = st_q.chain[STAGES-1];
        ev.rise  = st_q.chain[STAGES-1] & ~st_q.prev;
        ev.fall  = ~st_q.chain[STAGES-1] & st_q.prev;
    end

endmodule

// File: rtl/pdc_frame_ctl.sv
module pdc_frame_ctl
    import pdc_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int ENTER_MIN = 2,
    parameter int WAKE_MIN  = 10
) (
    input  logic     clk,
    input  logic     rst_n,
    input  edge_ev_t cs_ev,
    input  edge_ev_t sclk_ev,
    output logic     pwr_up,
    output logic     data_valid,
    output logic     frame_done,
    output logic     frame_open,
    output logic     load_word,
    output logic     shift_bit
);

    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             asleep;
        logic             start_asleep;
        logic             valid;
        logic             done;
    } ctl_st_t;

    ctl_st_t  st_d, st_q;
    logic     edge_hit;
    logic [CNT_W-1:0] cnt_eff;
    verdict_e verdict;

    // A falling edge counts only inside an open frame and below saturation.
    always_comb begin
        edge_hit = st_q.active && sclk_ev.fall && (int'(st_q.cnt) < FRAME_LEN);
        cnt_eff  = st_q.cnt + CNT_W'(edge_hit);
    end

    // Frame outcome from the effective count and the state at frame start.
    always_comb begin
        verdict = VERDICT_KEEP;
        if (st_q.asleep) begin
            if (int'(cnt_eff) >= WAKE_MIN) begin
                verdict = VERDICT_WAKE;
            end
        end else begin
            if ((int'(cnt_eff) >= ENTER_MIN) && (int'(cnt_eff) < WAKE_MIN)) begin
                verdict = VERDICT_SLEEP;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (cs_ev.fall) begin
            st_d.active       = 1'b1;
            st_d.cnt          = '0;
            st_d.start_asleep = st_q.asleep;
        end else if (cs_ev.rise && st_q.active) begin
            st_d.active = 1'b0;
            st_d.cnt    = cnt_eff;
            st_d.done   = 1'b1;
            st_d.valid  = !st_q.start_asleep && (int'(cnt_eff) == FRAME_LEN);
            case (verdict)
                VERDICT_SLEEP: st_d.asleep = 1'b1;
                VERDICT_WAKE:  st_d.asleep = 1'b0;
                default:       st_d.asleep = st_q.asleep;
            endcase
        end else if (st_q.active) begin
            st_d.cnt = cnt_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pwr_up     = !st_q.asleep;
        data_valid = st_q.valid;
        frame_done = st_q.done;
        frame_open = st_q.active;
        load_word  = cs_ev.fall;
        shift_bit  = edge_hit && !cs_ev.rise;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= FRAME_LEN); // R1
    AST_PWR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up != $past(pwr_up)) |-> frame_done); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R10
    AST_OE_OFF_ON_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_up) |-> !frame_open); // R8
    AST_VALID_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> pwr_up); // R7

endmodule

// File: rtl/pdc_shifter.sv
module pdc_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_word,
    input  logic              shift_bit,
    input  logic [DATA_W-1:0] word_in,
    output logic              bit_out
);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_word) begin
            st_d.sh = word_in;
        end else if (shift_bit) begin
            st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.sh[DATA_W-1];

    AST_LOAD_SHOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        load_word |=> (bit_out == $past(word_in[DATA_W-1]))); // R9

endmodule

// File: rtl/pdc_adc_ctl.sv
module pdc_adc_ctl
    import pdc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FRAME_LEN   = 16,
    parameter int ENTER_MIN   = 2,
    parameter int WAKE_MIN    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              sclk_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdata_out,
    output logic              sdata_oe,
    output logic              pwr_up,
    output logic              data_valid,
    output logic              frame_done
);

    localparam int N_IN   = 2;
    localparam int IDX_CS = 0;
    localparam int IDX_SK = 1;

    logic [N_IN-1:0] raw_in;
    edge_ev_t        ev [N_IN];
    logic            load_word, shift_bit, frame_open;

    assign raw_in = {sclk_in, cs_n_in};

    // Both inputs idle high and pass through equal-length chains.
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
        pdc_edge_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(raw_in[gi]),
            .ev      (ev[gi])
        );
    end

    pdc_frame_ctl #(
        .FRAME_LEN(FRAME_LEN),
        .ENTER_MIN(ENTER_MIN),
        .WAKE_MIN (WAKE_MIN)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_ev     (ev[IDX_CS]),
        .sclk_ev   (ev[IDX_SK]),
        .pwr_up    (pwr_up),
        .data_valid(data_valid),
        .frame_done(frame_done),
        .frame_open(frame_open),
        .load_word (load_word),
        .shift_bit (shift_bit)
    );

    pdc_shifter #(
        .DATA_W(DATA_W)
    ) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_word(load_word),
        .shift_bit(shift_bit),
        .word_in  (sample_in),
        .bit_out  (sdata_out)
    );

    assign sdata_oe = frame_open;

    AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !sdata_oe); // R8

endmodule

// File: tb/pdc_adc_ctl_test.sv
module pdc_adc_ctl_test;

    localparam int DW = 16;
    localparam int FL = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n;
    logic          sclk;
    logic [DW-1:0] word;
    logic          sdata_out, sdata_oe, pwr_up, data_valid, frame_done;

    always #2 clk = ~clk;

    pdc_adc_ctl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_in   (cs_n),
        .sclk_in   (sclk),
        .sample_in (word),
        .sdata_out (sdata_out),
        .sdata_oe  (sdata_oe),
        .pwr_up    (pwr_up),
        .data_valid(data_valid),
        .frame_done(frame_done)
    );

    typedef struct {
        bit    pwr;
        bit    valid;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   model_asleep = 1'b0;
    bit   finished = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: predicts the outcome, pushes it, then plays the frame.
    task automatic run_frame(int n, bit coincide, bit check_data, string tag);
        bit start_asleep;
        int cnt_eff;
        start_asleep = model_asleep;
        cnt_eff = (n > FL) ? FL : n;
        if (model_asleep) begin
            if (cnt_eff >= 10) model_asleep = 1'b0;
        end else if (cnt_eff >= 2 && cnt_eff < 10) begin
            model_asleep = 1'b1;
        end
        exp_q.push_back('{pwr: !model_asleep,
                          valid: (!start_asleep && cnt_eff == FL),
                          tag: tag});
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(6);
        chk({"R8 oe open ", tag}, 32'(sdata_oe), 32'd1);
        for (int i = 0; i < n; i++) begin
            if (check_data && i < DW)
                chk({"R9 data bit ", tag}, 32'(sdata_out), 32'(word[DW-1-i]));
            if (coincide && i == n - 1) begin
                sclk = 1'b0;
                cs_n = 1'b1;
            end else begin
                sclk = 1'b0;
                wait_clk(4);
                sclk = 1'b1;
                wait_clk(4);
            end
        end
        if (!coincide) cs_n = 1'b1;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(8);
        chk({"R10 hold pwr ", tag}, 32'(pwr_up), 32'(!model_asleep));
        chk({"R8 oe closed ", tag}, 32'(sdata_oe), 32'd0);
    endtask

    // Monitor: pops one expectation per frame end.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && frame_done === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected frame_done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({"R2-6 pwr ", e.tag}, 32'(pwr_up), 32'(e.pwr));
                chk({"R7 valid ", e.tag}, 32'(data_valid), 32'(e.valid));
                chk({"R8 oe at end ", e.tag}, 32'(sdata_oe), 32'd0);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sclk  = 1'b1;
        word  = 16'hA5C3;
        wait_clk(4);
        chk("R11 reset pwr", 32'(pwr_up), 32'd1);
        chk("R11 reset valid", 32'(data_valid), 32'd0);
        chk("R11 reset oe", 32'(sdata_oe), 32'd0);
        chk("R11 reset done", 32'(frame_done), 32'd0);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R11 after reset pwr", 32'(pwr_up), 32'd1);

        run_frame(16, 1'b0, 1'b1, "R7 full frame");
        run_frame(1,  1'b0, 1'b0, "R3 one edge");
        run_frame(0,  1'b0, 1'b0, "R3 no edge");
        run_frame(2,  1'b0, 1'b0, "R2 two edges");
        run_frame(8,  1'b0, 1'b0, "R5 burst of 8");
        run_frame(9,  1'b0, 1'b0, "R5 nine edges");
        run_frame(10, 1'b0, 1'b0, "R6 wake at 10");
        word = 16'h3C5A;
        run_frame(16, 1'b0, 1'b1, "R7 after wake");
        run_frame(9,  1'b0, 1'b0, "R2 nine edges");
        run_frame(16, 1'b0, 1'b0, "R6 R7 wake full");
        run_frame(12, 1'b0, 1'b0, "R4 twelve edges");
        run_frame(2,  1'b1, 1'b0, "R12 coincident 2nd");
        run_frame(10, 1'b1, 1'b0, "R12 coincident 10th");
        word = 16'h8001;
        run_frame(16, 1'b1, 1'b1, "R12 coincident 16th");
        run_frame(17, 1'b0, 1'b0, "R1 saturate 17");
        run_frame(1,  1'b1, 1'b0, "R12 R3 coincident 1st");

        wait_clk(10);
        chk("R10 every frame ended", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule